// File: doc/BRIEF.md
# Signed Slice Recoder with Zero-Slice Skipping

This block accepts a stream of two's-complement operands and rewrites each one as a short list of signed radix-16 digits. It then sends only the digits that carry information to the next stage. The recoding works upward from the least significant 4-bit slice and carries 0 or 1 between slices. Any slice whose sum with the incoming carry reaches 8 or more is turned into a negative digit, and it hands a carry upward. With this rule a run of sign-extension ones collapses to zero digits, for example in a small negative number. Positive and negative digit values also come out in roughly equal numbers.

Along with each operand the caller supplies a per-slice mask. A set mask bit marks that slice's digit as speculated away, so it is treated as zero. Zero digits are never emitted. Every surviving digit leaves on its own output beat, tagged with its slice position, most significant first. The final beat of an operand is flagged. If nothing survives, one marker beat with a zero flag closes the operand. Downstream logic can rebuild the operand as the sum of digit times 16 to the power of the position.

The control is a three-state machine. `ST_IDLE` waits with `in_ready` high. On an accepted operand it moves to `ST_EMIT` if at least one digit survives, and to `ST_ZERO` otherwise. `ST_EMIT` presents the highest pending digit and clears it when the beat is taken. It returns to `ST_IDLE` on the beat that takes the final digit. `ST_ZERO` presents the marker beat and returns to `ST_IDLE` when that beat is taken.

Top module: `bsr_recoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Digits are two's-complement values in `out_digit`. Slices below the top get digit = slice + carry when that sum is below 8, and otherwise sum − 16 with a carry of 1 upward. The top slice is read as a signed 4-bit value plus the incoming carry, so it lies in −8..+8 while every other digit lies in −8..+7. With no mask, the sum of digit·16^idx over the emitted beats equals the operand.
- R3: Sign-extension slices of all ones recode to zero through the borrow. For example, operand 0xFFFF emits a single beat with digit −1 at index 0.
- R4: A beat with `out_zero` = 0 never carries a zero digit.
- R5: Within one operand, beats come out in strictly descending `out_idx` order.
- R6: A slice whose `in_mask` bit (bit i for slice i, captured with the operand) is set is never emitted. The digits of unmasked slices are the same as with no mask, because the carry chain still runs through masked slices.
- R7: `out_last` is 1 on exactly the final beat of each operand and 0 on all others.
- R8: When every digit is zero or masked, exactly one beat is sent with `out_zero` = 1, `out_last` = 1, `out_digit` = 0 and `out_idx` = 0.
- R9: `in_ready` is 0 from the cycle after an operand is accepted until its final beat is taken, so operands never overlap.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value into the next cycle.
- R11: The first beat is valid in the cycle right after acceptance. With `out_ready` held high, the beats follow one per cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block can accept an operand |
| in_data | input | DATA_W | Two's-complement operand |
| in_mask | input | DATA_W/4 | Per-slice speculation mask, bit i for slice i |
| out_valid | output | 1 | Digit beat offered |
| out_ready | input | 1 | Downstream takes the beat |
| out_digit | output | 5 | Signed digit, two's complement |
| out_idx | output | clog2(DATA_W/4) | Slice position of the digit |
| out_last | output | 1 | Final beat of the operand |
| out_zero | output | 1 | Marker beat: no digit survived |

## Verification
The borrow carry and the speculation mask can act on the same operand in the same cycle. A masked low slice still feeds its carry into the slices above it, while its own digit has to vanish. The bench provokes this with operands such as 0x7FFF and 0xFFFF under masks on the low slices. It also sweeps pseudo-random operand and mask pairs under alternating backpressure. Each run is judged by comparing every emitted beat against a digit list built from the R2 rule with the masked positions removed. Unmasked operands are also checked by rebuilding their value from the beats.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int SLICE_W = 4;
    localparam int DIGIT_W = SLICE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EMIT,
        ST_ZERO
    } bsr_state_e;
endpackage

// File: rtl/bsr_slice_recode.sv
// Combinational signed radix-16 recoding, least significant slice first.
module bsr_slice_recode
    import bsr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int NSLICE = DATA_W / SLICE_W
) (
    input  logic [DATA_W-1:0]                raw,
    output logic [NSLICE-1:0][DIGIT_W-1:0]   dig
);
    logic [NSLICE-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar g = 0; g < NSLICE; g++) begin : g_sl
        logic [DIGIT_W-1:0] sum;
        if (g < NSLICE - 1) begin : g_low
            // unsigned slice plus carry, 0..16
            assign sum       = {1'b0, raw[g*SLICE_W +: SLICE_W]}
                             + {{(DIGIT_W-1){1'b0}}, cy[g]};
            assign cy[g+1]   = (sum >= DIGIT_W'(8));
            assign dig[g]    = cy[g+1] ? (sum - DIGIT_W'(16)) : sum;
        end else begin : g_top
            // top slice is signed and absorbs the last carry (-8..+8)
            assign sum       = {raw[g*SLICE_W + SLICE_W - 1], raw[g*SLICE_W +: SLICE_W]}
                             + {{(DIGIT_W-1){1'b0}}, cy[g]};
            assign dig[g]    = sum;
        end
    end
endmodule

// File: rtl/bsr_pick_top.sv
// Finds the highest pending slice and whether it is the only one left.
module bsr_pick_top #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic          single
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        single = found && ((pend & (pend - N'(1))) == '0);
    end
endmodule

// File: rtl/bsr_recoder.sv
module bsr_recoder
    import bsr_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int NSLICE = DATA_W / SLICE_W,
    localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [NSLICE-1:0]  in_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DIGIT_W-1:0] out_digit,
    output logic [IDX_W-1:0]   out_idx,
    output logic               out_last,
    output logic               out_zero
);
    bsr_state_e                      state, state_nx;
    logic [NSLICE-1:0][DIGIT_W-1:0]  rec_dig;
    logic [NSLICE-1:0][DIGIT_W-1:0]  dig_q;
    logic [NSLICE-1:0]               live_in;
    logic [NSLICE-1:0]               pend_q;
    logic [NSLICE-1:0]               pend_clr;
    logic                            pk_found;
    logic [IDX_W-1:0]                pk_idx;
    logic                            pk_single;
    logic                            accept;
    logic                            take;

    bsr_slice_recode #(.DATA_W(DATA_W)) u_recode (
        .raw (in_data),
        .dig (rec_dig)
    );

    // a digit survives when it is non-zero and not speculated away
    for (genvar g = 0; g < NSLICE; g++) begin : g_live
        assign live_in[g] = (rec_dig[g] != '0) && !in_mask[g];
    end

    bsr_pick_top #(.N(NSLICE), .IW(IDX_W)) u_pick (
        .pend   (pend_q),
        .found  (pk_found),
        .idx    (pk_idx),
        .single (pk_single)
    );

    assign accept = (state == ST_IDLE) && in_valid;
    assign take   = out_valid && out_ready;

    always_comb begin
        pend_clr         = pend_q;
        pend_clr[pk_idx] = 1'b0;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = (|live_in) ? ST_EMIT : ST_ZERO;
            ST_EMIT: if (out_ready && pk_single) state_nx = ST_IDLE;
            ST_ZERO: if (out_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operand digits and pending-slice set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dig_q  <= '0;
            pend_q <= '0;
        end else if (accept) begin
            dig_q  <= rec_dig;
            pend_q <= live_in;
        end else if ((state == ST_EMIT) && take) begin
            pend_q <= pend_clr;
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_digit = '0;
        out_idx   = '0;
        out_last  = 1'b0;
        out_zero  = 1'b0;
        unique case (state)
            ST_IDLE: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = pk_found;
                out_digit = dig_q[pk_idx];
                out_idx   = pk_idx;
                out_last  = pk_single;
            end
            ST_ZERO: begin
                out_valid = 1'b1;
                out_last  = 1'b1;
                out_zero  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bsr_recoder_chk.sv
module bsr_recoder_chk #(
    parameter int DATA_W = 16,
    localparam int NSLICE = DATA_W / 4,
    localparam int IDX_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [NSLICE-1:0]  in_mask,
    input logic               out_valid,
    input logic               out_ready,
    input logic [4:0]         out_digit,
    input logic [IDX_W-1:0]   out_idx,
    input logic               out_last,
    input logic               out_zero
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NSLICE - 1);

    logic [NSLICE-1:0] mask_cap;
    always_ff @(posedge clk) begin
        if (!rst_n)                    mask_cap <= '0;
        else if (in_valid && in_ready) mask_cap <= in_mask;
    end

    a_r4_no_zero_digit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero |-> out_digit != 5'd0);

    a_r2_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero |->
            ($signed(out_digit) >= -5'sd8) &&
            ((out_idx == TOP_IDX) ? ($signed(out_digit) <= 5'sd8)
                                  : ($signed(out_digit) <= 5'sd7)));

    a_r5_descending: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid && (out_idx < $past(out_idx)));

    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_zero |-> !mask_cap[out_idx]);

    a_r8_marker_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_zero |-> out_last && out_digit == 5'd0 && out_idx == '0);

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_digit) && $stable(out_idx)
                                    && $stable(out_last) && $stable(out_zero));

    a_r11_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
endmodule

bind bsr_recoder bsr_recoder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mask   (in_mask),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_digit (out_digit),
    .out_idx   (out_idx),
    .out_last  (out_last),
    .out_zero  (out_zero)
);

// File: tb/bsr_recoder_test.sv
`timescale 1ns/1ps
module bsr_recoder_test;
    localparam int DATA_W = 16;
    localparam int NS     = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [15:0]   in_data;
    logic [3:0]    in_mask;
    logic          out_valid;
    logic          out_ready;
    logic [4:0]    out_digit;
    logic [1:0]    out_idx;
    logic          out_last;
    logic          out_zero;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    bsr_recoder #(.DATA_W(DATA_W)) uut (.*);

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // digit rule of R2
    function automatic void model(input logic [15:0] v, output int d[NS]);
        int c = 0;
        for (int i = 0; i < NS; i++) begin
            int raw = (v >> (4*i)) & 15;
            if (i == NS-1) begin
                if (raw >= 8) raw -= 16;
                d[i] = raw + c;
            end else if (raw + c >= 8) begin
                d[i] = raw + c - 16; c = 1;
            end else begin
                d[i] = raw + c; c = 0;
            end
        end
    endfunction

    task automatic run_op(input logic [15:0] v, input logic [3:0] m, input bit stall);
        int d[NS];
        int ex_idx[NS];
        int ex_dig[NS];
        int ne = 0, k = 0, sum = 0, guard = 0;
        bit done = 0, tog = 0, held = 0;
        int h_dig = 0, h_idx = 0;
        model(v, d);
        for (int i = NS-1; i >= 0; i--)
            if (d[i] != 0 && !m[i]) begin
                ex_idx[ne] = i; ex_dig[ne] = d[i]; ne++;
            end
        @(negedge clk);
        in_data = v; in_mask = m; in_valid = 1'b1; out_ready = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid === 1'b1, "R11", "beat right after accept", out_valid, 1);
        while (!done && guard < 64) begin
            guard++;
            out_ready = stall ? tog : 1'b1;
            tog = ~tog;
            if (held) begin
                check($signed(out_digit) == h_dig && out_idx == h_idx && out_valid,
                      "R10", "held beat", $signed(out_digit), h_dig);
                held = 0;
            end
            if (!stall) check(out_valid === 1'b1, "R11", "no gap", out_valid, 1);
            if (out_valid) check(in_ready === 1'b0, "R9", "in_ready while draining", in_ready, 0);
            if (out_valid && !out_ready) begin
                held = 1; h_dig = $signed(out_digit); h_idx = out_idx;
            end
            if (out_valid && out_ready) begin
                if (ne == 0) begin
                    check(out_zero && out_last && out_digit == 0 && out_idx == 0,
                          "R8", "marker beat", {out_zero, out_last, out_idx}, 6'b11_00);
                    done = 1;
                end else begin
                    check(out_zero == 1'b0, "R8", "zero flag on digit", out_zero, 0);
                    check($signed(out_digit) != 0, "R4", "zero digit emitted", $signed(out_digit), ex_dig[k]);
                    check(out_idx == ex_idx[k], "R5", "slice order / R6 mask", out_idx, ex_idx[k]);
                    check($signed(out_digit) == ex_dig[k], "R2", "digit value", $signed(out_digit), ex_dig[k]);
                    check(out_last == (k == ne-1), "R7", "last flag", out_last, k == ne-1);
                    sum += $signed(out_digit) * (1 << (4*out_idx));
                    k++;
                    if (out_last || k >= ne) done = 1;
                end
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(done, "R7", "operand closed", done, 1);
        check(in_ready === 1'b1, "R9", "ready after drain", in_ready, 1);
        if (m == 0 && ne > 0)
            check(sum == int'($signed(v)), "R2", "rebuilt value", sum, int'($signed(v)));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_mask = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1", "in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R1", "after reset", in_ready, 1);
    endtask

    task automatic t_plain;   // R2, R5, R7, R11
        run_op(16'h1234, 4'h0, 0);
        run_op(16'h7FFF, 4'h0, 0);
        run_op(16'h8000, 4'h0, 0);
        run_op(16'h0008, 4'h0, 0);
        run_op(16'h7777, 4'h0, 0);
        run_op(16'h0888, 4'h0, 0);
    endtask

    task automatic t_sign;    // R3: all-ones slices borrow to zero
        run_op(16'hFFFF, 4'h0, 0);
        run_op(16'hFFFE, 4'h0, 0);
        run_op(16'hFFF0, 4'h0, 0);
        run_op(16'hFF80, 4'h0, 0);
    endtask

    task automatic t_mask;    // R6: carry runs through masked slices
        run_op(16'h7FFF, 4'b0001, 0);
        run_op(16'h1234, 4'b0011, 0);
        run_op(16'h89AB, 4'b0101, 1);
    endtask

    task automatic t_allzero; // R8
        run_op(16'h0000, 4'h0, 0);
        run_op(16'hFFFF, 4'b0001, 0);
        run_op(16'h1234, 4'hF, 1);
    endtask

    task automatic t_stall;   // R10
        run_op(16'h5A5A, 4'h0, 1);
        run_op(16'hC3C3, 4'h0, 1);
    endtask

    task automatic t_sweep;
        logic [15:0] lf = 16'hACE1;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_op(lf, (n % 3 == 0) ? lf[3:0] ^ lf[11:8] : 4'h0, n[0]);
        end
    endtask

    initial begin
        t_reset;
        t_plain;
        t_sign;
        t_mask;
        t_allzero;
        t_stall;
        t_sweep;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule